// File: doc/BRIEF.md
# Shift, Rotate and Status-Bit Unit

This block works on one data byte together with an 8-bit status byte. It does logical shifts in both directions, rotates in both directions through the carry flag, an arithmetic right shift and a nibble exchange. It can also move a single bit between the data byte and the transfer flag, in either direction. It can set or clear any one status bit chosen by index. Each operation takes one cycle. The caller presents an operand, an operation code, a bit index and the current status byte with a valid strobe. One clock edge later the new data byte and the new status byte appear on registered outputs, with a matching valid pulse.

The status byte has this layout, from bit 7 down to bit 0: I (interrupt enable), T (transfer), H (half carry), S (sign), V (overflow), N (negative), Z (zero), C (carry). Shifts and rotates compute the flags from that layout. The other operations either leave the status byte as it was or change only the one bit they address.

Top module: `shbit_unit`

## Requirements
- R1: With op = 0, the result is the operand shifted left by one, with 0 entering bit 0. Old bit 7 goes to C, and H takes old operand bit 3.
- R2: With op = 1, the result is the operand shifted right by one, with 0 entering bit 7. Old bit 0 goes to C, and H keeps its input value.
- R3: With op = 2 (rotate left), old C enters bit 0 and old bit 7 goes to C; H takes old operand bit 3. With op = 3 (rotate right), old C enters bit 7 and old bit 0 goes to C; H keeps its input value.
- R4: With op = 4, bits 7..1 move down by one, bit 7 keeps its value, and old bit 0 goes to C. H keeps its input value.
- R5: With op = 5, bits 3:0 and bits 7:4 of the operand trade places. The status byte comes out exactly as it went in.
- R6: For ops 0 to 4, the output flags are set as follows. Z is 1 when the result is zero. N equals result bit 7. V equals N xor C, and S equals N xor V. I (bit 7) and T (bit 6) keep their input values.
- R7: With op = 6, T (status bit 6) takes operand bit bit_idx. The result equals the operand, and every other status bit is unchanged.
- R8: With op = 7, result bit bit_idx takes T, and every other result bit equals the operand. The status byte is unchanged.
- R9: With op = 8, status bit bit_idx is set to 1. With op = 9, status bit bit_idx is cleared to 0. All other status bits are unchanged in both cases, and the result equals the operand.
- R10: With op codes 10 to 15, the result equals the operand and the status byte is unchanged.
- R11: Outputs are registered. Inputs accepted on the edge where in_valid is 1 appear after that edge, with out_valid = 1. When in_valid is 0, out_valid is 0 and the result and status outputs hold. Synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operation on this edge |
| op | input | 4 | Operation code (see requirements) |
| operand | input | 8 | Data byte to operate on |
| bit_idx | input | 3 | Bit selector for bit transfer and flag set/clear |
| status_in | input | 8 | Current status byte (I T H S V N Z C, bit 7 to 0) |
| out_valid | output | 1 | Result registered from an accepted operation |
| result | output | 8 | New data byte |
| status_out | output | 8 | New status byte |

## Verification
The hardest cases to reach are the ones where each flag rule can be told apart from the others. The operand and incoming carry must make C and N differ, so that V = N xor C and S = N xor V do not collapse to constants. For the rules that keep H, the incoming H must be set, since otherwise "kept" and "cleared" look the same. The stimulus table therefore picks operands such as 0x88, 0x41 and 0x81 with chosen carry and H inputs. It also includes cases whose result is zero. Directed sequences then sweep every flag index and check that the outputs hold while in_valid is low.

// File: rtl/shbit_pkg.sv
package shbit_pkg;

  localparam int STAT_W = 8;

  // Status byte positions; the flag logic depends on this order
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_ROL  = 4'd2,
    OP_ROR  = 4'd3,
    OP_ASR  = 4'd4,
    OP_SWAP = 4'd5,
    OP_BST  = 4'd6,
    OP_BLD  = 4'd7,
    OP_FSET = 4'd8,
    OP_FCLR = 4'd9
  } shbit_op_e;

  function automatic logic is_shift_op(input logic [3:0] code);
    return code <= 4'd4;
  endfunction

endpackage

// File: rtl/shbit_shifter.sv
module shbit_shifter
  import shbit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]        op,
  input  logic [W-1:0]      operand,
  input  logic [STAT_W-1:0] status_in,
  output logic              hit,
  output logic [W-1:0]      res,
  output logic [STAT_W-1:0] st
);
  localparam int HALF = W / 2;

  logic c_new;
  logic h_upd;
  logic n_new;
  logic v_new;

  always_comb begin
    hit   = 1'b1;
    res   = operand;
    c_new = 1'b0;
    h_upd = 1'b0;
    case (shbit_op_e'(op))
      OP_SHL: begin
        res   = {operand[W-2:0], 1'b0};
        c_new = operand[W-1];
        h_upd = 1'b1;
      end
      OP_SHR: begin
        res   = {1'b0, operand[W-1:1]};
        c_new = operand[0];
      end
      OP_ROL: begin
        res   = {operand[W-2:0], status_in[FL_C]};
        c_new = operand[W-1];
        h_upd = 1'b1;
      end
      OP_ROR: begin
        res   = {status_in[FL_C], operand[W-1:1]};
        c_new = operand[0];
      end
      OP_ASR: begin
        res   = {operand[W-1], operand[W-1:1]};
        c_new = operand[0];
      end
      default: hit = 1'b0;
    endcase

    n_new = res[W-1];
    v_new = n_new ^ c_new;
    st    = status_in;
    if (hit) begin
      st[FL_C] = c_new;
      st[FL_Z] = (res == '0);
      st[FL_N] = n_new;
      st[FL_V] = v_new;
      st[FL_S] = n_new ^ v_new;
      if (h_upd) st[FL_H] = operand[HALF-1];
    end
  end

endmodule

// File: rtl/shbit_bitops.sv
module shbit_bitops
  import shbit_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [3:0]        op,
  input  logic [W-1:0]      operand,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [STAT_W-1:0] status_in,
  output logic [W-1:0]      res,
  output logic [STAT_W-1:0] st
);
  localparam int HALF = W / 2;

  logic [2:0] flag_sel;
  assign flag_sel = 3'(bit_idx);

  always_comb begin
    res = operand;
    st  = status_in;
    case (shbit_op_e'(op))
      OP_SWAP: res = {operand[HALF-1:0], operand[W-1:HALF]};
      OP_BST:  st[FL_T] = operand[bit_idx];
      OP_BLD:  res[bit_idx] = status_in[FL_T];
      OP_FSET: st[flag_sel] = 1'b1;
      OP_FCLR: st[flag_sel] = 1'b0;
      default: ;
    endcase
  end

endmodule

// File: rtl/shbit_unit.sv
module shbit_unit
  import shbit_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [W-1:0]      operand,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [STAT_W-1:0] status_in,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic [STAT_W-1:0] status_out
);

  logic              sh_hit;
  logic [W-1:0]      sh_res;
  logic [STAT_W-1:0] sh_st;
  logic [W-1:0]      bo_res;
  logic [STAT_W-1:0] bo_st;

  shbit_shifter #(.W(W)) u_shift (
    .op        (op),
    .operand   (operand),
    .status_in (status_in),
    .hit       (sh_hit),
    .res       (sh_res),
    .st        (sh_st)
  );

  shbit_bitops #(.W(W), .IDX_W(IDX_W)) u_bits (
    .op        (op),
    .operand   (operand),
    .bit_idx   (bit_idx),
    .status_in (status_in),
    .res       (bo_res),
    .st        (bo_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      status_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= sh_hit ? sh_res : bo_res;
        status_out <= sh_hit ? sh_st : bo_st;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && status_out == '0)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(status_out))); // R11

  AST_SHL_FILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SHL) |=> (result[0] == 1'b0 && status_out[FL_C] == $past(operand[W-1]))); // R1

  AST_SHR_FILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SHR) |=> (result[W-1] == 1'b0 && status_out[FL_C] == $past(operand[0]))); // R2

  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ROL) |=> (result[0] == $past(status_in[FL_C]))); // R3

  AST_ASR_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ASR) |=> (result[W-1] == $past(operand[W-1]))); // R4

  AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SWAP) |=> (status_out == $past(status_in))); // R5

  AST_SHIFT_VFLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_shift_op(op)) |=>
      (status_out[FL_V] == (status_out[FL_N] ^ status_out[FL_C]) &&
       status_out[FL_N] == result[W-1] &&
       status_out[FL_I:FL_T] == $past(status_in[FL_I:FL_T]))); // R6

  AST_BLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_BLD) |=> (status_out == $past(status_in))); // R8

  AST_FSET_BIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_FSET) |=> (result == $past(operand) &&
      $countones(status_out ^ $past(status_in)) <= 1)); // R9

  AST_SPARE_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd10) |=> (result == $past(operand) && status_out == $past(status_in))); // R10

endmodule

// File: tb/tb_shbit_unit.sv
module tb_shbit_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [3:0] op;
  logic [7:0] operand;
  logic [2:0] bit_idx;
  logic [7:0] status_in;
  logic       out_valid;
  logic [7:0] result;
  logic [7:0] status_out;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  shbit_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
    .bit_idx(bit_idx), .status_in(status_in), .out_valid(out_valid),
    .result(result), .status_out(status_out)
  );

  // {op, operand, idx, status_in, expected result, expected status}
  localparam int NV = 18;
  localparam logic [38:0] VEC [NV] = '{
    {4'd0, 8'h88, 3'd0, 8'h00, 8'h10, 8'h39},  // R1 carry out, H from bit3
    {4'd0, 8'h80, 3'd0, 8'hC0, 8'h00, 8'hDB},  // R1 zero result, I/T kept
    {4'd0, 8'h08, 3'd0, 8'h00, 8'h10, 8'h20},  // R1 H only
    {4'd1, 8'h01, 3'd0, 8'h20, 8'h00, 8'h3B},  // R2 H kept
    {4'd1, 8'hFE, 3'd0, 8'h00, 8'h7F, 8'h00},  // R2
    {4'd2, 8'h41, 3'd0, 8'h01, 8'h83, 8'h0C},  // R3 rotate left
    {4'd3, 8'h02, 3'd0, 8'h01, 8'h81, 8'h0C},  // R3 rotate right, C in
    {4'd3, 8'h03, 3'd0, 8'h00, 8'h01, 8'h19},  // R3 rotate right, C out
    {4'd4, 8'h81, 3'd0, 8'h00, 8'hC0, 8'h15},  // R4 sign kept
    {4'd4, 8'h01, 3'd0, 8'h00, 8'h00, 8'h1B},  // R4 zero
    {4'd5, 8'h3C, 3'd0, 8'hA5, 8'hC3, 8'hA5},  // R5
    {4'd6, 8'h10, 3'd4, 8'h00, 8'h10, 8'h40},  // R7 T set
    {4'd6, 8'h10, 3'd3, 8'hFF, 8'h10, 8'hBF},  // R7 T cleared
    {4'd7, 8'h00, 3'd7, 8'h40, 8'h80, 8'h40},  // R8 load 1
    {4'd7, 8'hFF, 3'd0, 8'hBF, 8'hFE, 8'hBF},  // R8 load 0
    {4'd8, 8'h5A, 3'd7, 8'h00, 8'h5A, 8'h80},  // R9 set
    {4'd9, 8'h5A, 3'd1, 8'hFF, 8'h5A, 8'hFD},  // R9 clear
    {4'd12, 8'h77, 3'd5, 8'h33, 8'h77, 8'h33}  // R10 spare code
  };

  function automatic string req_of(input logic [3:0] code, input bit is_status);
    if (code <= 4'd4 && is_status) return "R6";
    case (code)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [7:0] d,
                       input logic [2:0] i, input logic [7:0] s);
    @(negedge clk);
    in_valid = 1'b1; op = c; operand = d; bit_idx = i; status_in = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; operand = '0; bit_idx = '0; status_in = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check8("R11", "reset valid", {7'd0, out_valid}, 8'h00);
    check8("R11", "reset result", result, 8'h00);
    check8("R11", "reset status", status_out, 8'h00);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][38:35], VEC[k][34:27], VEC[k][26:24], VEC[k][23:16]);
      check8("R11", "valid", {7'd0, out_valid}, 8'h01);
      check8(req_of(VEC[k][38:35], 1'b0), $sformatf("vec%0d result", k), result, VEC[k][15:8]);
      check8(req_of(VEC[k][38:35], 1'b1), $sformatf("vec%0d status", k), status_out, VEC[k][7:0]);
    end

    // R11 hold while idle: change inputs without in_valid
    issue(4'd0, 8'hAA, 3'd2, 8'h11);
    check8("R11", "pre-hold result", result, 8'h54);
    @(negedge clk);
    op = 4'd5; operand = 8'hF0; status_in = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    check8("R11", "idle valid", {7'd0, out_valid}, 8'h00);
    check8("R11", "hold result", result, 8'h54);
    check8("R11", "hold status", status_out, 8'h39);

    // R9 sweep every flag index, set then clear
    for (int b = 0; b < 8; b++) begin
      issue(4'd8, 8'h00, 3'(b), 8'h00);
      check8("R9", $sformatf("set idx %0d", b), status_out, 8'(1 << b));
      issue(4'd9, 8'h00, 3'(b), 8'hFF);
      check8("R9", $sformatf("clear idx %0d", b), status_out, ~8'(1 << b));
    end

    // R8 load T into every bit position
    for (int b = 0; b < 8; b++) begin
      issue(4'd7, 8'h00, 3'(b), 8'h40);
      check8("R8", $sformatf("load idx %0d", b), result, 8'(1 << b));
    end

    // R10 all spare codes
    for (int c = 10; c < 16; c++) begin
      issue(4'(c), 8'h96, 3'd1, 8'h5C);
      check8("R10", $sformatf("code %0d result", c), result, 8'h96);
      check8("R10", $sformatf("code %0d status", c), status_out, 8'h5C);
    end

    // R11 reset in mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check8("R11", "mid reset result", result, 8'h00);
    check8("R11", "mid reset status", status_out, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule